// File: doc/BRIEF.md
# Floppy Drive Output Register Decoder

This block is the host-visible output-control register pair of a floppy disk controller. A byte-wide register bus writes an output-control byte and a tape-assignment byte. The block turns the control byte into active-low drive-select and motor-on lines for two drives. It also drives a level that holds the rest of the controller in reset, and an enable for the DMA and interrupt paths whose meaning depends on a mode input.

The output-control byte carries four fields. A two-bit drive number selects a drive. An active-low soft-reset bit holds the controller in reset. A DMA/interrupt gate bit controls those paths. Four motor-enable bits follow, of which only the two for drives 0 and 1 reach pins. A drive-select line asserts only when its drive is addressed and its motor bit is set. The soft-reset output is stretched so that a write of 0 followed directly by a write of 1 still produces a reset pulse of the guaranteed minimum length. The tape-assignment register keeps a two-bit drive number. A soft reset leaves it unchanged.

Top module: `fdc_outreg_top`

## Requirements
- R1: After the hardware reset input (rst_n low) is released, the control byte reads 0x00 and the tape field reads 00. Both sel_n bits and both motor_n bits are 1, ctl_reset is 1, and dma_irq_en is 0 while mode is 2'b00.
- R2: motor_n[i] equals the inverse of control-byte bit 4+i, for i = 0 and 1.
- R3: sel_n[0] is 0 only when control bits 1:0 are 00 and bit 4 is 1. sel_n[1] is 0 only when bits 1:0 are 01 and bit 5 is 1. Drive numbers 10 and 11 leave both selects at 1.
- R4: At most one sel_n bit is 0 at any time.
- R5: Control bits 7:6 are stored and read back, and they have no effect on any drive-interface output.
- R6: While control bit 2 holds 0, ctl_reset is 1. Writing bit 2 as 0 does not alter the other control bits or the tape field.
- R7: Each ctl_reset pulse lasts at least MIN_RST_CYC cycles (default 25, which is 100 ns at 250 MHz). A write of 0 to bit 2 followed on the very next cycle by a write of 1 yields a pulse of exactly MIN_RST_CYC cycles.
- R8: In modes 2'b00 and 2'b10, dma_irq_en follows control bit 3. In mode 2'b01, dma_irq_en is 1 whatever bit 3 holds. The output takes its new value at the clock edge that captures a write or mode change.
- R9: The tape register sits at offset 3. It stores written bits 1:0 (00 means no drive, 01 to 11 mean drives 1 to 3). A read returns those bits with rdata_oe = 0x03 and bits 7:2 undriven (0 with oe clear).
- R10: The control register sits at offset 2. A read returns all eight bits with rdata_oe = 0xFF. Writes to other offsets change nothing, and reads of other offsets return oe = 0x00.
- R11: sel_n, motor_n and dma_irq_en are registered and change at the clock edge that captures the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| mode | input | 2 | 00 and 10 gate DMA with bit 3; 01 forces it on |
| bus_rdata | output | 8 | Read data |
| bus_rdata_oe | output | 8 | Per-bit read-data drive enable |
| sel_n | output | NUM_DRIVES | Drive selects, active low |
| motor_n | output | NUM_DRIVES | Motor-on lines, active low |
| ctl_reset | output | 1 | Controller reset level, active high |
| dma_irq_en | output | 1 | DMA and interrupt enable |

## Verification
The hardest case to reach is the shortest possible soft reset. Bit 2 must be cleared on one cycle and set again on the very next, so the stored bit is low for a single cycle, and the stretched pulse must still last the full minimum. The stimulus issues two write strobes on consecutive edges with nothing between them. It then counts the high cycles of ctl_reset at every falling edge until the pulse ends. A second scenario holds bit 2 low across many cycles and then checks that the tape field and the other control bits are unchanged.

// File: rtl/fdc_outreg_pkg.sv
package fdc_outreg_pkg;
   typedef enum logic [1:0] {
      MODE_GATED_A = 2'b00,
      MODE_ALWAYS  = 2'b01,
      MODE_GATED_B = 2'b10,
      MODE_RSVD    = 2'b11
   } dma_mode_e;

   localparam int CTL_RST_BIT = 2;
   localparam int CTL_DMA_BIT = 3;
   localparam int CTL_MTR_LSB = 4;
   localparam int TAPE_W      = 2;
endpackage

// File: rtl/fdc_outreg_regs.sv
module fdc_outreg_regs #(
   parameter int ADDR_W  = 3,
   parameter int CTL_OFS = 2,
   parameter int TAP_OFS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [7:0]        ctl_q,
   output logic [7:0]        ctl_d,
   output logic [7:0]        bus_rdata,
   output logic [7:0]        bus_rdata_oe
);
   import fdc_outreg_pkg::*;

   localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_OFS);
   localparam logic [ADDR_W-1:0] TAP_A = ADDR_W'(TAP_OFS);

   logic [TAPE_W-1:0] tape_q;
   logic              ctl_hit, tap_hit;

   assign ctl_hit = bus_wr && (bus_addr == CTL_A);
   assign tap_hit = bus_wr && (bus_addr == TAP_A);
   assign ctl_d   = ctl_hit ? bus_wdata : ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         tape_q <= '0;
      end else begin
         ctl_q <= ctl_d;
         if (tap_hit) tape_q <= bus_wdata[TAPE_W-1:0];
      end
   end

   always_comb begin
      bus_rdata    = '0;
      bus_rdata_oe = '0;
      if (bus_rd) begin
         if (bus_addr == CTL_A) begin
            bus_rdata    = ctl_q;
            bus_rdata_oe = 8'hFF;
         end else if (bus_addr == TAP_A) begin
            bus_rdata[TAPE_W-1:0]    = tape_q;
            bus_rdata_oe[TAPE_W-1:0] = '1;
         end
      end
   end
endmodule

// File: rtl/fdc_outreg_decode.sv
module fdc_outreg_decode #(
   parameter int NUM_DRIVES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [7:0]            ctl_d,
   input  logic [1:0]            mode,
   output logic [NUM_DRIVES-1:0] sel_n,
   output logic [NUM_DRIVES-1:0] motor_n,
   output logic                  dma_irq_en
);
   import fdc_outreg_pkg::*;

   logic [NUM_DRIVES-1:0] sel_nx, mtr_nx;
   logic                  dma_nx;

   for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_drv
      assign mtr_nx[i] = ~ctl_d[CTL_MTR_LSB+i];
      assign sel_nx[i] = ~((ctl_d[1:0] == 2'(i)) && ctl_d[CTL_MTR_LSB+i]);
   end

   assign dma_nx = (dma_mode_e'(mode) == MODE_ALWAYS) || ctl_d[CTL_DMA_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_n      <= '1;
         motor_n    <= '1;
         dma_irq_en <= 1'b0;
      end else begin
         sel_n      <= sel_nx;
         motor_n    <= mtr_nx;
         dma_irq_en <= dma_nx;
      end
   end
endmodule

// File: rtl/fdc_outreg_rststretch.sv
module fdc_outreg_rststretch #(
   parameter int MIN_RST_CYC = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_n,
   output logic ctl_reset
);
   if (MIN_RST_CYC <= 1) begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ctl_reset <= 1'b1;
         else        ctl_reset <= ~hold_n;
      end
   end else begin : g_count
      localparam int CNT_W = $clog2(MIN_RST_CYC + 1);
      localparam logic [CNT_W-1:0] RELOAD = CNT_W'(MIN_RST_CYC - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctl_reset <= 1'b1;
            cnt_q     <= RELOAD;
         end else if (!hold_n) begin
            ctl_reset <= 1'b1;
            cnt_q     <= RELOAD;
         end else if (cnt_q != '0) begin
            ctl_reset <= 1'b1;
            cnt_q     <= cnt_q - 1'b1;
         end else begin
            ctl_reset <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/fdc_outreg_top.sv
module fdc_outreg_top #(
   parameter int ADDR_W      = 3,
   parameter int CTL_OFS     = 2,
   parameter int TAP_OFS     = 3,
   parameter int NUM_DRIVES  = 2,
   parameter int MIN_RST_CYC = 25
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [7:0]            bus_wdata,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [1:0]            mode,
   output logic [7:0]            bus_rdata,
   output logic [7:0]            bus_rdata_oe,
   output logic [NUM_DRIVES-1:0] sel_n,
   output logic [NUM_DRIVES-1:0] motor_n,
   output logic                  ctl_reset,
   output logic                  dma_irq_en
);
   import fdc_outreg_pkg::*;

   if (NUM_DRIVES < 1 || NUM_DRIVES > 2) begin : g_bad_drives
      $error("NUM_DRIVES must be 1 or 2");
   end
   if (CTL_OFS == TAP_OFS || CTL_OFS >= (1 << ADDR_W) || TAP_OFS >= (1 << ADDR_W)) begin : g_bad_ofs
      $error("register offsets must differ and fit ADDR_W");
   end
   if (MIN_RST_CYC < 1) begin : g_bad_rst
      $error("MIN_RST_CYC must be at least 1");
   end

   logic [7:0] ctl_q, ctl_d;

   fdc_outreg_regs #(.ADDR_W(ADDR_W), .CTL_OFS(CTL_OFS), .TAP_OFS(TAP_OFS)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .ctl_q(ctl_q), .ctl_d(ctl_d),
      .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe)
   );

   fdc_outreg_decode #(.NUM_DRIVES(NUM_DRIVES)) u_dec (
      .clk(clk), .rst_n(rst_n), .ctl_d(ctl_d), .mode(mode),
      .sel_n(sel_n), .motor_n(motor_n), .dma_irq_en(dma_irq_en)
   );

   fdc_outreg_rststretch #(.MIN_RST_CYC(MIN_RST_CYC)) u_rst (
      .clk(clk), .rst_n(rst_n), .hold_n(ctl_q[CTL_RST_BIT]), .ctl_reset(ctl_reset)
   );
endmodule

// File: rtl/fdc_outreg_chk.sv
module fdc_outreg_chk #(
   parameter int ADDR_W      = 3,
   parameter int CTL_OFS     = 2,
   parameter int TAP_OFS     = 3,
   parameter int NUM_DRIVES  = 2,
   parameter int MIN_RST_CYC = 25
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic [7:0]            bus_wdata,
   input logic                  bus_wr,
   input logic                  bus_rd,
   input logic [1:0]            mode,
   input logic [7:0]            bus_rdata_oe,
   input logic [NUM_DRIVES-1:0] sel_n,
   input logic [NUM_DRIVES-1:0] motor_n,
   input logic                  ctl_reset,
   input logic                  dma_irq_en
);
   localparam int HW = $clog2(MIN_RST_CYC + 2);
   logic [HW-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     hi_cnt <= '0;
      else if (!ctl_reset)            hi_cnt <= '0;
      else if (hi_cnt != HW'(MIN_RST_CYC)) hi_cnt <= hi_cnt + 1'b1;
   end

   // R4
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~sel_n));

   for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_drv
      // R3
      sel_needs_motor_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !sel_n[i] |-> !motor_n[i]);
   end

   // R7
   rst_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl_reset) |-> (hi_cnt >= HW'(MIN_RST_CYC)));

   // R6
   rst_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(CTL_OFS) && !bus_wdata[2]) |-> ##2 ctl_reset);

   // R8
   dma_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01) |=> dma_irq_en);

   // R9
   tape_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(TAP_OFS)) |-> (bus_rdata_oe == 8'h03));

   // R10
   ctl_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(CTL_OFS)) |-> (bus_rdata_oe == 8'hFF));
endmodule

bind fdc_outreg_top fdc_outreg_chk #(
   .ADDR_W(ADDR_W), .CTL_OFS(CTL_OFS), .TAP_OFS(TAP_OFS),
   .NUM_DRIVES(NUM_DRIVES), .MIN_RST_CYC(MIN_RST_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_wr(bus_wr), .bus_rd(bus_rd), .mode(mode), .bus_rdata_oe(bus_rdata_oe),
   .sel_n(sel_n), .motor_n(motor_n), .ctl_reset(ctl_reset), .dma_irq_en(dma_irq_en)
);

// File: tb/fdc_outreg_top_tb.sv
module fdc_outreg_top_tb;
   localparam int N = 25;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0] mode = 2'b00;
   logic [7:0] bus_rdata, bus_rdata_oe;
   logic [1:0] sel_n, motor_n;
   logic       ctl_reset, dma_irq_en;

   int checks = 0, fails = 0;
   bit done = 0;

   typedef struct packed { logic [1:0] sel_n; logic [1:0] mtr_n; logic dma; } exp_t;
   exp_t exp_q[$];
   logic [7:0] m_ctl = 8'h00;

   always #2 clk = ~clk;

   fdc_outreg_top u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .mode(mode), .bus_rdata(bus_rdata),
      .bus_rdata_oe(bus_rdata_oe), .sel_n(sel_n), .motor_n(motor_n),
      .ctl_reset(ctl_reset), .dma_irq_en(dma_irq_en)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic exp_t model();
      exp_t e;
      for (int i = 0; i < 2; i++) begin
         e.mtr_n[i] = ~m_ctl[4+i];
         e.sel_n[i] = ~((m_ctl[1:0] == 2'(i)) && m_ctl[4+i]);
      end
      e.dma = (mode == 2'b01) || m_ctl[3];
      return e;
   endfunction

   // driver: one write, then expected output snapshot into the scoreboard
   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      if (a == 3'd2) m_ctl = d;
      exp_q.push_back(model());
      #1 bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic [7:0] oe);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata; oe = bus_rdata_oe;
      bus_rd = 1'b0;
   endtask

   // monitor: compare registered outputs after the capturing edge (R11)
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e, a;
         e = exp_q.pop_front();
         a = {sel_n, motor_n, dma_irq_en};
         chk(a.sel_n == e.sel_n, "R3/R11 sel_n", 32'(a.sel_n), 32'(e.sel_n));
         chk(a.mtr_n == e.mtr_n, "R2/R11 motor_n", 32'(a.mtr_n), 32'(e.mtr_n));
         chk(a.dma == e.dma, "R8/R11 dma_irq_en", 32'(a.dma), 32'(e.dma));
      end
   end

   initial begin
      #200000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] d, oe;
      int hi;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(sel_n == 2'b11 && motor_n == 2'b11, "R1 outputs", {sel_n, motor_n}, 4'hF);
      chk(ctl_reset == 1'b1 && dma_irq_en == 1'b0, "R1 rst/dma", {ctl_reset, dma_irq_en}, 2'b10);
      rd(3'd2, d, oe);
      chk(d == 8'h00, "R1 ctl byte", d, 8'h00);
      rd(3'd3, d, oe);
      chk(d == 8'h00, "R1 tape field", d, 8'h00);

      // R2 R3 patterns
      wr(3'd2, 8'h14);
      wr(3'd2, 8'h25);
      wr(3'd2, 8'h15);  // drive 1 addressed, motor 1 off
      wr(3'd2, 8'h36);  // R3 drive 2 -> no select
      wr(3'd2, 8'h37);  // R3 drive 3 -> no select
      wr(3'd2, 8'hC4);  // R5 bits 7:6 only
      rd(3'd2, d, oe);
      chk(d == 8'hC4, "R5 readback", d, 8'hC4);
      chk(oe == 8'hFF, "R10 ctl oe", oe, 8'hFF);
      wr(3'd2, 8'hF4);
      wr(3'd2, 8'h0C);  // R8 gated mode, bit 3 set

      // R10 ignored offsets
      wr(3'd0, 8'hFF);
      wr(3'd5, 8'h10);
      rd(3'd2, d, oe);
      chk(d == 8'h0C, "R10 other offset write ignored", d, 8'h0C);
      rd(3'd6, d, oe);
      chk(oe == 8'h00, "R10 other offset oe", oe, 8'h00);

      // R8 modes
      @(negedge clk); mode = 2'b01;
      repeat (2) @(negedge clk);
      wr(3'd2, 8'h04);
      @(negedge clk); mode = 2'b10;
      repeat (2) @(negedge clk);
      wr(3'd2, 8'h08);
      wr(3'd2, 8'h04);
      @(negedge clk); mode = 2'b00;

      // R9 tape register
      wr(3'd3, 8'hFE);
      rd(3'd3, d, oe);
      chk(d == 8'h02, "R9 tape data", d, 8'h02);
      chk(oe == 8'h03, "R9 tape oe", oe, 8'h03);

      // wait for the reset pulse from power-up to end
      repeat (N + 5) @(negedge clk);
      chk(ctl_reset == 1'b0, "R7 released", ctl_reset, 1'b0);

      // R6 held soft reset
      wr(3'd2, 8'h35);
      wr(3'd2, 8'h31);
      repeat (3 * N) @(negedge clk);
      chk(ctl_reset == 1'b1, "R6 held while bit2=0", ctl_reset, 1'b1);
      rd(3'd2, d, oe);
      chk(d == 8'h31, "R6 other bits kept", d, 8'h31);
      rd(3'd3, d, oe);
      chk(d == 8'h02, "R9 tape kept over soft reset", d, 8'h02);
      wr(3'd2, 8'h35);
      repeat (N + 5) @(negedge clk);
      chk(ctl_reset == 1'b0, "R6 released after bit2=1", ctl_reset, 1'b0);

      // R7 back-to-back toggle
      wr(3'd2, 8'h30);
      wr(3'd2, 8'h34);
      hi = 0;
      for (int k = 0; k < 3 * N; k++) begin
         @(negedge clk);
         if (ctl_reset) hi++;
      end
      chk(hi == N, "R7 back-to-back pulse width", hi, N);

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R11 scoreboard drained", exp_q.size(), 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule